// File: doc/BRIEF.md
# Nested Core Event Controller

This block arbitrates sixteen fixed-priority core event levels, numbered 0 (most urgent) to 15. Each level request is caught in a latch register. A mask register chooses which latched levels may be serviced, and a pending register records every level that is in service, including levels that have nested inside one another. At each cycle the block offers the most urgent latched, unmasked level that may interrupt the work already in progress. The sequencer takes the offer with an accept strobe. At that point the latch bit clears and the pending bit sets. When a handler finishes, a return strobe retires the innermost active level.

Levels 7 to 15 can be switched on and off together with a global enable flag. The flag has separate set and clear strobes. Levels 0 to 6 do not respond to this flag. The three registers and the flag can be read through a small register port, and the latch and mask registers can be written through it, but only while the privilege input is high.

Top module: `nec_core_evt_ctrl`

## Requirements
- R1: After synchronous reset, the latch, mask and pending registers read 0, the global enable flag is 0, `svc_valid` is 0 and `reg_rdata` is 0.
- R2: A 1 on `evt_req[i]` sets latch bit i at the next clock edge, whatever the state of the mask. Latch bits are never cleared by their request line.
- R3: While `svc_valid` and `svc_accept` are both high at a clock edge, that edge clears latch bit `svc_level` and sets pending bit `svc_level`. If a request for the same level arrives in the same cycle, the latch bit stays set.
- R4: `svc_valid` and `svc_level` depend only on the registers. `svc_valid` is 1 exactly when some level is latched, has its mask bit at 1, is globally allowed and may preempt. In that case `svc_level` is the lowest-numbered such level.
- R5: The pending register cannot be written through the register port. A write to address 2 has no effect, and pending bits set only through acceptance (R3).
- R6: A level may preempt only if its number is strictly lower than every set pending bit. When no pending bit is set, any level may be offered.
- R7: At a clock edge where `ret_pulse` is 1, the lowest-numbered set pending bit clears. If no pending bit is set, nothing changes. An acceptance and a return in the same cycle both take effect, and the return acts on the pending bits as they stood before that edge.
- R8: `gie_set` sets the global enable flag and `gie_clr` clears it. If both are high, the clear takes effect. Levels 7 to 15 can be offered only while the flag is 1. Levels 0 to 6 ignore the flag. `gie` shows the flag.
- R9: A write to address 0 loads `reg_wdata` into the latch bits whose mask bit is 0 and leaves the other latch bits unchanged. Requests arriving in the same cycle are OR-ed in afterwards. A write to address 1 loads the mask register.
- R10: While `priv` is 0, register writes have no effect and a read returns 0.
- R11: Register map: address 0 is the latch register, 1 is the mask register, 2 is the pending register, and 3 is status, with bit 0 holding the global enable flag. A read strobed at one edge puts its data on `reg_rdata` at that edge, taken from the register values before the edge. The data then holds until the next read. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_req | input | 16 | Per-level event request, one bit per level |
| svc_accept | input | 1 | Sequencer takes the offered level |
| ret_pulse | input | 1 | Return from the innermost active level |
| gie_set | input | 1 | Set the global enable flag |
| gie_clr | input | 1 | Clear the global enable flag |
| priv | input | 1 | Privilege qualifier for register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| svc_valid | output | 1 | A level is offered for service |
| svc_level | output | 4 | Offered level number |
| gie | output | 1 | Global enable flag |

## Verification
The assertions make no demands on the inputs. `svc_accept` and `ret_pulse` may arrive at any time, and an accept with no offer does nothing. As a result, the bench's random phase drives every strobe freely, including accept and return in the same cycle and clashing enable strobes. The acceptance property excludes the cycle in which the accepted level is requested again, because R3 keeps the latch bit set in that case. The return property excludes the cycle in which an acceptance also adds a pending bit.

// File: rtl/nec_pkg.sv
package nec_pkg;
  localparam int unsigned NEC_ADDR_W = 2;

  typedef enum logic [NEC_ADDR_W-1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_STAT  = 2'd3
  } nec_sel_e;
endpackage

// File: rtl/nec_lowest_bit.sv
// Finds the lowest-numbered set bit of a vector.
module nec_lowest_bit #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/nec_arbiter.sv
// Chooses the level to offer and isolates the innermost pending level.
module nec_arbiter #(
  parameter int LEVELS     = 16,
  parameter int GATED_FROM = 7,
  localparam int IW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [LEVELS-1:0] latch_q,
  input  logic [LEVELS-1:0] mask_q,
  input  logic [LEVELS-1:0] pend_q,
  input  logic              gie_q,
  output logic              offer_valid,
  output logic [IW-1:0]     offer_idx,
  output logic [LEVELS-1:0] pend_low_oh
);
  logic [LEVELS-1:0] allow;
  logic [LEVELS-1:0] below_pend;
  logic [LEVELS-1:0] eligible;

  for (genvar g = 0; g < LEVELS; g++) begin : g_allow
    if (g < GATED_FROM) begin : g_fixed
      assign allow[g] = 1'b1;
    end else begin : g_gated
      assign allow[g] = gie_q;
    end
  end

  // Lowest pending bit as a one-hot; minus one yields every level above it
  // in priority (all ones when nothing is pending).
  assign pend_low_oh = pend_q & (~pend_q + LEVELS'(1));
  assign below_pend  = pend_low_oh - LEVELS'(1);
  assign eligible    = latch_q & mask_q & allow & below_pend;

  nec_lowest_bit #(.W(LEVELS)) pick_i (
    .vec   (eligible),
    .found (offer_valid),
    .idx   (offer_idx)
  );
endmodule

// File: rtl/nec_bus_port.sv
// Privilege-qualified register port with registered read data.
module nec_bus_port
  import nec_pkg::*;
#(
  parameter int LEVELS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  priv,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [NEC_ADDR_W-1:0] reg_addr,
  input  logic [LEVELS-1:0]     latch_q,
  input  logic [LEVELS-1:0]     mask_q,
  input  logic [LEVELS-1:0]     pend_q,
  input  logic                  gie_q,
  output logic                  wr_latch,
  output logic                  wr_mask,
  output logic [LEVELS-1:0]     reg_rdata
);
  nec_sel_e          sel;
  logic [LEVELS-1:0] rd_mux;

  assign sel      = nec_sel_e'(reg_addr);
  assign wr_latch = reg_wr && priv && (sel == SEL_LATCH);
  assign wr_mask  = reg_wr && priv && (sel == SEL_MASK);

  always_comb begin
    unique case (sel)
      SEL_LATCH: rd_mux = latch_q;
      SEL_MASK:  rd_mux = mask_q;
      SEL_PEND:  rd_mux = pend_q;
      default:   rd_mux = {{(LEVELS-1){1'b0}}, gie_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= priv ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/nec_core_evt_ctrl.sv
module nec_core_evt_ctrl
  import nec_pkg::*;
#(
  parameter int LEVELS     = 16,
  parameter int GATED_FROM = 7,
  localparam int IDX_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LEVELS-1:0]     evt_req,
  input  logic                  svc_accept,
  input  logic                  ret_pulse,
  input  logic                  gie_set,
  input  logic                  gie_clr,
  input  logic                  priv,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [NEC_ADDR_W-1:0] reg_addr,
  input  logic [LEVELS-1:0]     reg_wdata,
  output logic [LEVELS-1:0]     reg_rdata,
  output logic                  svc_valid,
  output logic [IDX_W-1:0]      svc_level,
  output logic                  gie
);
  logic [LEVELS-1:0] latch_q, mask_q, pend_q;
  logic              gie_q;
  logic              offer_valid;
  logic [IDX_W-1:0]  offer_idx;
  logic [LEVELS-1:0] pend_low_oh;
  logic              wr_latch, wr_mask;
  logic              acc_fire;
  logic [LEVELS-1:0] acc_oh, ret_oh, latch_wr_val, latch_d, pend_d;

  nec_arbiter #(.LEVELS(LEVELS), .GATED_FROM(GATED_FROM)) arb_i (
    .latch_q     (latch_q),
    .mask_q      (mask_q),
    .pend_q      (pend_q),
    .gie_q       (gie_q),
    .offer_valid (offer_valid),
    .offer_idx   (offer_idx),
    .pend_low_oh (pend_low_oh)
  );

  nec_bus_port #(.LEVELS(LEVELS)) bus_i (
    .clk       (clk),
    .rst       (rst),
    .priv      (priv),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .latch_q   (latch_q),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .gie_q     (gie_q),
    .wr_latch  (wr_latch),
    .wr_mask   (wr_mask),
    .reg_rdata (reg_rdata)
  );

  assign acc_fire = offer_valid && svc_accept;
  assign acc_oh   = acc_fire  ? (LEVELS'(1) << offer_idx) : '0;
  assign ret_oh   = ret_pulse ? pend_low_oh : '0;

  // Software may only touch latch bits whose mask bit is clear.
  assign latch_wr_val = wr_latch ? ((latch_q & mask_q) | (reg_wdata & ~mask_q)) : latch_q;
  assign latch_d      = (latch_wr_val & ~acc_oh) | evt_req;
  // The accepted level always lies above the innermost pending one, so the
  // return and the acceptance never meet on the same bit.
  assign pend_d       = (pend_q & ~ret_oh) | acc_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      gie_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      pend_q  <= pend_d;
      if (wr_mask) mask_q <= reg_wdata;
      if (gie_clr)      gie_q <= 1'b0;
      else if (gie_set) gie_q <= 1'b1;
    end
  end

  assign svc_valid = offer_valid;
  assign svc_level = offer_idx;
  assign gie       = gie_q;
endmodule

// File: rtl/nec_core_evt_ctrl_chk.sv
module nec_core_evt_ctrl_chk #(
  parameter int LEVELS     = 16,
  parameter int GATED_FROM = 7,
  localparam int IDX_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [LEVELS-1:0] evt_req,
  input logic              svc_accept,
  input logic              ret_pulse,
  input logic              priv,
  input logic              reg_wr,
  input logic              svc_valid,
  input logic [IDX_W-1:0]  svc_level,
  input logic [LEVELS-1:0] latch_q,
  input logic [LEVELS-1:0] mask_q,
  input logic [LEVELS-1:0] pend_q,
  input logic              gie_q
);
  logic p_found;
  int   p_idx;

  always_comb begin
    p_found = 1'b0;
    p_idx   = 0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        p_found = 1'b1;
        p_idx   = i;
      end
    end
  end

  assert_offer_latched_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> (latch_q[svc_level] && mask_q[svc_level]));

  assert_offer_preempts_R6: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && p_found) |-> (int'(svc_level) < p_idx));

  assert_global_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && !gie_q) |-> (int'(svc_level) < GATED_FROM));

  assert_accept_moves_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && svc_accept && !evt_req[svc_level])
      |=> (pend_q[$past(svc_level)] && !latch_q[$past(svc_level)]));

  assert_return_retires_one_R7: assert property (@(posedge clk) disable iff (rst)
    (ret_pulse && !(svc_valid && svc_accept) && (pend_q != '0))
      |=> ($countones(pend_q) + 1 == $past($countones(pend_q))));

  assert_pend_rises_on_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & ~$past(pend_q))) |-> $past(svc_valid && svc_accept));

  assert_unpriv_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !priv) |=> $stable(mask_q));
endmodule

bind nec_core_evt_ctrl nec_core_evt_ctrl_chk #(
  .LEVELS(LEVELS), .GATED_FROM(GATED_FROM)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .evt_req    (evt_req),
  .svc_accept (svc_accept),
  .ret_pulse  (ret_pulse),
  .priv       (priv),
  .reg_wr     (reg_wr),
  .svc_valid  (svc_valid),
  .svc_level  (svc_level),
  .latch_q    (latch_q),
  .mask_q     (mask_q),
  .pend_q     (pend_q),
  .gie_q      (gie_q)
);

// File: tb/nec_core_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module nec_core_evt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_req = '0;
  logic        svc_accept = 1'b0, ret_pulse = 1'b0, gie_set = 1'b0, gie_clr = 1'b0;
  logic        priv = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        svc_valid;
  logic [3:0]  svc_level;
  logic        gie;

  int n_checks = 0;
  int n_fail   = 0;
  bit compare_on = 1'b0;

  always #4 clk = ~clk;

  nec_core_evt_ctrl dut_i (
    .clk(clk), .rst(rst), .evt_req(evt_req), .svc_accept(svc_accept),
    .ret_pulse(ret_pulse), .gie_set(gie_set), .gie_clr(gie_clr), .priv(priv),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .svc_valid(svc_valid), .svc_level(svc_level), .gie(gie)
  );

  // ---------------- reference model ----------------
  bit [15:0] m_latch, m_mask, m_pend, m_rdata;
  bit        m_gie;

  function automatic void m_offer(output bit v, output int lvl);
    v = 1'b0; lvl = 0;
    for (int i = 0; i < 16; i++) begin
      if (m_pend[i]) break;
      if (m_latch[i] && m_mask[i] && (i < 7 || m_gie)) begin
        v = 1'b1; lvl = i; break;
      end
    end
  endfunction

  always @(posedge clk) begin
    bit v; int lvl;
    bit [15:0] old_mask;
    if (rst) begin
      m_latch = '0; m_mask = '0; m_pend = '0; m_rdata = '0; m_gie = 1'b0;
    end else begin
      m_offer(v, lvl);
      old_mask = m_mask;
      if (reg_rd) begin
        if (!priv) m_rdata = '0;
        else case (reg_addr)
          2'd0: m_rdata = m_latch;
          2'd1: m_rdata = m_mask;
          2'd2: m_rdata = m_pend;
          default: m_rdata = {15'd0, m_gie};
        endcase
      end
      if (reg_wr && priv && reg_addr == 2'd0)
        for (int i = 0; i < 16; i++) if (!old_mask[i]) m_latch[i] = reg_wdata[i];
      if (reg_wr && priv && reg_addr == 2'd1) m_mask = reg_wdata;
      if (ret_pulse)
        for (int i = 0; i < 16; i++) if (m_pend[i]) begin m_pend[i] = 1'b0; break; end
      if (v && svc_accept) begin m_latch[lvl] = 1'b0; m_pend[lvl] = 1'b1; end
      m_latch = m_latch | evt_req;
      if (gie_clr) m_gie = 1'b0;
      else if (gie_set) m_gie = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Every-clock comparison, away from the active edge.
  always @(negedge clk) begin
    bit v; int lvl;
    if (compare_on && !rst) begin
      m_offer(v, lvl);
      chk(svc_valid == v, "R4 svc_valid", int'(svc_valid), int'(v));
      if (v) chk(int'(svc_level) == lvl, "R4 svc_level", int'(svc_level), lvl);
      chk(reg_rdata == m_rdata, "R11 reg_rdata", int'(reg_rdata), int'(m_rdata));
      chk(gie == m_gie, "R8 gie", int'(gie), int'(m_gie));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle_inputs();
    evt_req = '0; svc_accept = 1'b0; ret_pulse = 1'b0; gie_set = 1'b0;
    gie_clr = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic accept_once();
    @(negedge clk); svc_accept = 1'b1;
    @(negedge clk); svc_accept = 1'b0;
  endtask

  task automatic ret_once();
    @(negedge clk); ret_pulse = 1'b1;
    @(negedge clk); ret_pulse = 1'b0;
  endtask

  task automatic req(input logic [15:0] r);
    @(negedge clk); evt_req = r;
    @(negedge clk); evt_req = '0;
  endtask

  task automatic offer_chk(input bit v, input int lvl, input string tag);
    @(negedge clk);
    chk(svc_valid == v, tag, int'(svc_valid), int'(v));
    if (v) chk(int'(svc_level) == lvl, tag, int'(svc_level), lvl);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    compare_on = 1'b1;
    // R1 reset state
    offer_chk(1'b0, 0, "R1 svc_valid after reset");
    chk(reg_rdata == 16'h0, "R1 rdata after reset", int'(reg_rdata), 0);
    rd_chk(2'd0, 16'h0000, "R1 latch reset");
    rd_chk(2'd1, 16'h0000, "R1 mask reset");
    rd_chk(2'd2, 16'h0000, "R1 pend reset");
    rd_chk(2'd3, 16'h0000, "R1 status reset");
    // R9 latch writes through a clear mask, blocked where mask is set
    wr(2'd0, 16'h00F0);
    rd_chk(2'd0, 16'h00F0, "R9 latch write with mask clear");
    wr(2'd1, 16'h00F0);
    wr(2'd0, 16'h0000);
    rd_chk(2'd0, 16'h00F0, "R9 masked latch bits unchanged");
    offer_chk(1'b1, 4, "R4 lowest unmasked level offered");
    // R3 acceptance
    accept_once();
    rd_chk(2'd2, 16'h0010, "R3 pend set on accept");
    rd_chk(2'd0, 16'h00E0, "R3 latch cleared on accept");
    offer_chk(1'b0, 0, "R6 lower priority cannot preempt");
    // R2 request latched while masked
    req(16'h0002);
    rd_chk(2'd0, 16'h00E2, "R2 request latched");
    offer_chk(1'b0, 0, "R4 masked level not offered");
    wr(2'd1, 16'h00F2);
    offer_chk(1'b1, 1, "R6 higher priority preempts");
    accept_once();
    rd_chk(2'd2, 16'h0012, "R3 nested pend");
    // R7 returns
    ret_once();
    rd_chk(2'd2, 16'h0010, "R7 innermost retired");
    ret_once();
    rd_chk(2'd2, 16'h0000, "R7 outer retired");
    ret_once();
    rd_chk(2'd2, 16'h0000, "R7 return with nothing pending");
    offer_chk(1'b1, 5, "R4 next level after returns");
    accept_once(); ret_once();
    offer_chk(1'b1, 6, "R4 level 6 not gated");
    accept_once(); ret_once();
    // R8 global gate
    offer_chk(1'b0, 0, "R8 level 7 blocked while disabled");
    @(negedge clk); gie_set = 1'b1;
    @(negedge clk); gie_set = 1'b0;
    offer_chk(1'b1, 7, "R8 level 7 offered when enabled");
    rd_chk(2'd3, 16'h0001, "R8 status shows enable");
    @(negedge clk); gie_set = 1'b1; gie_clr = 1'b1;
    @(negedge clk); gie_set = 1'b0; gie_clr = 1'b0;
    rd_chk(2'd3, 16'h0000, "R8 clear wins");
    @(negedge clk); gie_set = 1'b1;
    @(negedge clk); gie_set = 1'b0;
    accept_once();
    // R5 pending not writable
    wr(2'd2, 16'h0000);
    rd_chk(2'd2, 16'h0080, "R5 pend write ignored");
    ret_once();
    // R10 privilege
    @(negedge clk); priv = 1'b0;
    wr(2'd1, 16'h0000);
    rd_chk(2'd1, 16'h0000, "R10 unprivileged read gives 0");
    @(negedge clk); priv = 1'b1;
    rd_chk(2'd1, 16'h00F2, "R10 unprivileged write ignored");
    // R7 simultaneous accept and return
    req(16'h0010);
    accept_once();
    req(16'h0002);
    @(negedge clk); svc_accept = 1'b1; ret_pulse = 1'b1;
    @(negedge clk); svc_accept = 1'b0; ret_pulse = 1'b0;
    rd_chk(2'd2, 16'h0002, "R7 accept and return together");
    ret_once();
    // Random phase, compared against the model every clock
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      idle_inputs();
      evt_req    = 16'($urandom & $urandom & $urandom);
      svc_accept = ($urandom % 2) == 0;
      ret_pulse  = ($urandom % 5) == 0;
      gie_set    = ($urandom % 10) == 0;
      gie_clr    = ($urandom % 10) == 0;
      priv       = ($urandom % 10) != 0;
      reg_wr     = ($urandom % 8) == 0;
      reg_rd     = ($urandom % 3) == 0;
      reg_addr   = 2'($urandom);
      reg_wdata  = 16'($urandom);
    end
    @(negedge clk); idle_inputs(); priv = 1'b1;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule